// File: doc/BRIEF.md
# Write-Masked Pin Configuration Register Bank

This block holds the function-select, pull and drive settings for one bank of 32 pins. The pins are split into four groups of eight. Software programs it over a simple register bus with an address, a 32-bit write word, a write strobe and a registered read word. The design outputs decoded per-pin settings that pad logic can use directly.

In a normal write the upper halfword is a bit-enable mask for the lower halfword. Software can therefore change one field without first reading the register back. A group can instead be built as plain 32-bit writable, in which case the whole word is stored as written. Parameters fix the following per group:
- a function-select field width of 2, 3 or 4 bits;
- whether the group is limited to plain I/O;
- which of two pull encodings it uses.

A 3-bit drive field that starts at bit 15 of a drive register continues into the register above it.

Top module: `pcfg_bank`

## Requirements
- R1: After synchronous reset every register reads as zero, every pin reports function 0, pull code 0 (none) and drive 0.
- R2: In a masked group, a write to a mapped register changes lower bit n (0..15) only when write bit n+16 is set. Every other lower bit keeps its value, and the upper 16 bits read as zero.
- R3: In a plain 32-bit group, a write stores all 32 write bits unchanged. A read returns them, and the lower half is decoded even when the upper half of the written word was zero.
- R4: In a 2-bit function group, one register holds all eight pins. Pin k of the group (k = pin mod 8) takes bits [2k+1:2k], zero-extended to the 4-bit function output.
- R5: In a 3-bit function group, pins k=0..4 take bits [3k+2:3k] of the first register. Pins k=5..7 take bits [3(k-5)+2:3(k-5)] of the second register, which sits 4 bytes above the first.
- R6: In a 4-bit function group, pins k=0..3 take bits [4k+3:4k] of the first register. Pins k=4..7 take bits [4(k-4)+3:4(k-4)] of the second register.
- R7: Function registers start at byte 0x00. Each group adds 4 bytes if its width is 2 bits, or 8 bytes if its width is 3 or 4 bits. With the default parameters, group 1 uses 0x04/0x08, group 2 uses 0x0C/0x10 and group 3 uses 0x14/0x18.
- R8: A group limited to plain I/O always reports function 0 on its pins. Its function registers read as zero and ignore writes.
- R9: Each group has two drive registers at DRV_BASE+8g and DRV_BASE+8g+4. Pin k's 3-bit drive is bits [3k+2:3k] of the 32-bit value {second[15:0], first[15:0]}. For pin k=5 this puts value bit 0 at bit 15 of the first register (enable bit 31) and value bits 2:1 at bits 1:0 of the second register (enable bits 17:16).
- R10: The pull register of group g is at PULL_BASE+4g and holds a raw 2-bit field per pin at bits [2k+1:2k]. The output pull code is 0 none, 1 up, 2 down, 3 hold. Under encoding A the raw value maps 0/1/2/3 to none/up/down/hold. Under encoding B it maps 0/1/2/3 to none/down/none/up.
- R11: A read of an unmapped byte address returns zero. A write to one leaves every register and every pin output unchanged.
- R12: Read data appears one clock after the address is presented. A write is taken at the clock edge where the strobe is sampled, and pin outputs change one clock edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write word (upper half is the bit-enable mask in masked groups) |
| wr_en_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Registered read word |
| func_o | output | NGRP*32 | 4-bit function select per pin, pin p at [4p+3:4p] |
| pull_o | output | NGRP*16 | 2-bit normalized pull code per pin, pin p at [2p+1:2p] |
| drv_o | output | NGRP*24 | 3-bit drive code per pin, pin p at [3p+2:3p] |

## Verification
The bench builds the block with its default parameters:
- group 0 uses 2-bit function fields;
- group 1 uses 3-bit fields and pull encoding B;
- group 2 uses 4-bit fields, plain 32-bit writes and pull encoding B;
- group 3 uses 4-bit fields and is limited to plain I/O.

This mix puts every field layout, both write semantics, both pull encodings and the plain-I/O lockout into one run. It also places group 1's pin 5 on the split drive field.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int GRP_PINS = 8;
  localparam int FUNC_W   = 4;
  localparam int DRV_W    = 3;
  localparam int PULL_W   = 2;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_HOLD = 2'd3
  } pull_e;

  // Map a raw pull field to the normalized code for the group's encoding.
  function automatic pull_e pull_xlate(input logic enc_b, input logic [1:0] raw);
    if (!enc_b) return pull_e'(raw);
    case (raw)
      2'd1:    return PULL_DOWN;
      2'd3:    return PULL_UP;
      default: return PULL_NONE;
    endcase
  endfunction

  // New register value for a write, masked or plain.
  function automatic logic [31:0] wmask_merge(input logic [31:0] old,
                                              input logic [31:0] wd,
                                              input logic        plain);
    if (plain) return wd;
    return {16'h0000, (old[15:0] & ~wd[31:16]) | (wd[15:0] & wd[31:16])};
  endfunction
endpackage

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
  import pcfg_pkg::*;
#(
  parameter int                   NGRP       = 4,
  parameter int                   ADDR_W     = 8,
  parameter logic [NGRP-1:0][2:0] MUX_BITS   = {3'd4, 3'd4, 3'd3, 3'd2},
  parameter logic [NGRP-1:0]      GPIO_ONLY  = 4'b1000,
  parameter logic [NGRP-1:0]      PLAIN32    = 4'b0100,
  parameter int                   PULL_BASE  = 'h20,
  parameter int                   DRV_BASE   = 'h30,
  localparam int                  NSLOT      = 5 * NGRP
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  input  logic                        wr_en_i,
  output logic [31:0]                 rdata_o,
  output logic [NSLOT-1:0][31:0]      regs_o
);
  // Slot layout: function slots 2g/2g+1, pull slot 2*NGRP+g,
  // drive slots 3*NGRP+2g and 3*NGRP+2g+1.
  function automatic int mux_ofs(int g);
    int o;
    o = 0;
    for (int i = 0; i < NGRP; i++)
      if (i < g) o += (MUX_BITS[i] == 3'd2) ? 4 : 8;
    return o;
  endfunction

  function automatic int slot_grp(int s);
    if (s < 2 * NGRP)      return s / 2;
    else if (s < 3 * NGRP) return s - 2 * NGRP;
    else                   return (s - 3 * NGRP) / 2;
  endfunction

  function automatic int slot_addr(int s);
    if (s < 2 * NGRP)      return mux_ofs(s / 2) + (s % 2) * 4;
    else if (s < 3 * NGRP) return PULL_BASE + (s - 2 * NGRP) * 4;
    else                   return DRV_BASE + (s - 3 * NGRP) * 4;
  endfunction

  function automatic bit slot_used(int s);
    if (s < 2 * NGRP)
      return !GPIO_ONLY[s / 2] && ((s % 2) == 0 || MUX_BITS[s / 2] != 3'd2);
    return 1'b1;
  endfunction

  logic [31:0]      store_q [NSLOT];
  logic [NSLOT-1:0] hit;
  logic [31:0]      rd_d;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(slot_addr(s));
    localparam bit                SU = slot_used(s);
    localparam bit                SP = PLAIN32[slot_grp(s)];

    assign hit[s]    = SU && (addr_i == SA);
    assign regs_o[s] = store_q[s];

    always_ff @(posedge clk) begin
      if (rst)                  store_q[s] <= '0;
      else if (wr_en_i && hit[s]) store_q[s] <= wmask_merge(store_q[s], wdata_i, SP);
    end

    if (SP) begin : g_plain
      AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit[s]) |=> (store_q[s] == $past(wdata_i))); // R3
    end else begin : g_masked
      AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit[s]) |=>
        (((store_q[s][15:0] ^ $past(store_q[s][15:0])) & ~$past(wdata_i[31:16])) == 16'h0)); // R2
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        hit[s] |=> (rdata_o[31:16] == 16'h0)); // R2
    end
  end

  always_comb begin
    rd_d = '0;
    for (int s = 0; s < NSLOT; s++)
      if (hit[s]) rd_d = rd_d | store_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end

  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !(|hit)) |=> $stable(regs_o)); // R11
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    !(|hit) |=> (rdata_o == 32'h0)); // R11
endmodule

// File: rtl/pcfg_pin_decode.sv
module pcfg_pin_decode
  import pcfg_pkg::*;
#(
  parameter int                   NGRP       = 4,
  parameter logic [NGRP-1:0][2:0] MUX_BITS   = {3'd4, 3'd4, 3'd3, 3'd2},
  parameter logic [NGRP-1:0]      GPIO_ONLY  = 4'b1000,
  parameter logic [NGRP-1:0]      PULL_ENC_B = 4'b0110,
  localparam int                  NSLOT      = 5 * NGRP,
  localparam int                  NPIN       = NGRP * GRP_PINS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSLOT-1:0][31:0]     regs_i,
  output logic [NPIN*FUNC_W-1:0]     func_o,
  output logic [NPIN*PULL_W-1:0]     pull_o,
  output logic [NPIN*DRV_W-1:0]      drv_o
);
  logic [NPIN*FUNC_W-1:0] func_d;
  logic [NPIN*PULL_W-1:0] pull_d;
  logic [NPIN*DRV_W-1:0]  drv_d;
  logic                   unused_bits;

  // Not every stored bit feeds a pin field.
  assign unused_bits = ^regs_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int MS = 2 * g;
    localparam int PS = 2 * NGRP + g;
    localparam int DS = 3 * NGRP + 2 * g;
    logic [31:0] dcat;
    assign dcat = {regs_i[DS+1][15:0], regs_i[DS][15:0]};

    for (genvar k = 0; k < GRP_PINS; k++) begin : g_pin
      localparam int P = g * GRP_PINS + k;
      assign drv_d[P*DRV_W +: DRV_W]   = dcat[k*3 +: 3];
      assign pull_d[P*PULL_W +: PULL_W] = pull_xlate(PULL_ENC_B[g], regs_i[PS][k*2 +: 2]);

      if (GPIO_ONLY[g]) begin : g_io
        assign func_d[P*FUNC_W +: FUNC_W] = '0;
      end else if (MUX_BITS[g] == 3'd2) begin : g_w2
        assign func_d[P*FUNC_W +: FUNC_W] = {2'b00, regs_i[MS][k*2 +: 2]};
      end else if (MUX_BITS[g] == 3'd3) begin : g_w3
        if (k < 5) begin : g_lo
          assign func_d[P*FUNC_W +: FUNC_W] = {1'b0, regs_i[MS][k*3 +: 3]};
        end else begin : g_hi
          assign func_d[P*FUNC_W +: FUNC_W] = {1'b0, regs_i[MS+1][(k-5)*3 +: 3]};
        end
      end else begin : g_w4
        if (k < 4) begin : g_lo
          assign func_d[P*FUNC_W +: FUNC_W] = regs_i[MS][k*4 +: 4];
        end else begin : g_hi
          assign func_d[P*FUNC_W +: FUNC_W] = regs_i[MS+1][(k-4)*4 +: 4];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      func_o <= '0;
      pull_o <= '0;
      drv_o  <= '0;
    end else begin
      func_o <= func_d;
      pull_o <= pull_d;
      drv_o  <= drv_d;
    end
  end
endmodule

// File: rtl/pcfg_bank.sv
module pcfg_bank
  import pcfg_pkg::*;
#(
  parameter int                   NGRP       = 4,
  parameter int                   ADDR_W     = 8,
  parameter logic [NGRP-1:0][2:0] MUX_BITS   = {3'd4, 3'd4, 3'd3, 3'd2},
  parameter logic [NGRP-1:0]      GPIO_ONLY  = 4'b1000,
  parameter logic [NGRP-1:0]      PLAIN32    = 4'b0100,
  parameter logic [NGRP-1:0]      PULL_ENC_B = 4'b0110,
  parameter int                   PULL_BASE  = 'h20,
  parameter int                   DRV_BASE   = 'h30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    wr_en_i,
  output logic [31:0]             rdata_o,
  output logic [NGRP*32-1:0]      func_o,
  output logic [NGRP*16-1:0]      pull_o,
  output logic [NGRP*24-1:0]      drv_o
);
  localparam int NSLOT = 5 * NGRP;

  logic [NSLOT-1:0][31:0] regs;

  pcfg_regfile #(
    .NGRP(NGRP), .ADDR_W(ADDR_W), .MUX_BITS(MUX_BITS), .GPIO_ONLY(GPIO_ONLY),
    .PLAIN32(PLAIN32), .PULL_BASE(PULL_BASE), .DRV_BASE(DRV_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rdata_o(rdata_o), .regs_o(regs)
  );

  pcfg_pin_decode #(
    .NGRP(NGRP), .MUX_BITS(MUX_BITS), .GPIO_ONLY(GPIO_ONLY), .PULL_ENC_B(PULL_ENC_B)
  ) u_dec (
    .clk(clk), .rst(rst), .regs_i(regs),
    .func_o(func_o), .pull_o(pull_o), .drv_o(drv_o)
  );

  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en_i) && !$past(wr_en_i, 2)) |->
    ($stable(func_o) && $stable(pull_o) && $stable(drv_o))); // R12
endmodule

// File: tb/pcfg_bank_tb_top.sv
module pcfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic [127:0] func;
  logic [63:0]  pull;
  logic [95:0]  drv;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pcfg_bank dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rdata_o(rdata), .func_o(func), .pull_o(pull), .drv_o(drv)
  );

  function automatic logic [31:0] fn(int p);  return 32'(func[p*4 +: 4]); endfunction
  function automatic logic [31:0] pl(int p);  return 32'(pull[p*2 +: 2]); endfunction
  function automatic logic [31:0] dv(int p);  return 32'(drv[p*3 +: 3]);  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 reg 0x00", v, 0);
    rd(8'h30, v); chk("R1 reg 0x30", v, 0);
    chk("R1 func", (func == '0) ? 1 : 0, 1);
    chk("R1 pull", (pull == '0) ? 1 : 0, 1);
    chk("R1 drive", (drv == '0) ? 1 : 0, 1);
  endtask

  task automatic t_mask_2bit();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_A5A5); rd(8'h00, v); chk("R2 full enable", v, 32'h0000_A5A5);
    wr(8'h00, 32'h00F0_FFFF); rd(8'h00, v); chk("R2 set nibble", v, 32'h0000_A5F5);
    wr(8'h00, 32'h0F00_0000); rd(8'h00, v); chk("R2 clear nibble", v, 32'h0000_A0F5);
    wr(8'h00, 32'h0000_FFFF); rd(8'h00, v); chk("R2 no enable", v, 32'h0000_A0F5);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R4 pin%0d", k), fn(k), (32'hA0F5 >> (2*k)) & 32'h3);
  endtask

  task automatic t_mux3();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_58D1);
    wr(8'h08, 32'hFFFF_003E);
    rd(8'h08, v); chk("R7 group1 second reg", v, 32'h0000_003E);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R5 pin%0d", 8 + k), fn(8 + k), 32'((k + 1) % 8));
  endtask

  task automatic t_mux4_plain();
    logic [31:0] v;
    wr(8'h0C, 32'h1234_4321);
    wr(8'h10, 32'hDEAD_8765);
    rd(8'h0C, v); chk("R3 plain readback", v, 32'h1234_4321);
    rd(8'h10, v); chk("R7 group2 second reg", v, 32'hDEAD_8765);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R6 pin%0d", 16 + k), fn(16 + k), 32'(k + 1));
    wr(8'h0C, 32'h0000_00FF);
    rd(8'h0C, v); chk("R3 no mask", v, 32'h0000_00FF);
    chk("R3 pin16", fn(16), 32'hF);
    chk("R3 pin18", fn(18), 32'h0);
  endtask

  task automatic t_gpio_only();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R8 read zero", v, 0);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R8 pin%0d", 24 + k), fn(24 + k), 0);
  endtask

  task automatic t_drive();
    logic [31:0] v;
    wr(8'h30, 32'h01C0_0140);
    wr(8'h38, 32'h8000_8000);
    wr(8'h3C, 32'h0003_0002);
    rd(8'h3C, v);
    chk("R9 normal field pin2", dv(2), 5);
    chk("R9 split pin13", dv(13), 5);
    chk("R9 neighbour pin12", dv(12), 0);
    chk("R9 neighbour pin14", dv(14), 0);
    wr(8'h3C, 32'h00E0_00C0);
    rd(8'h3C, v); chk("R9 second reg", v, 32'h0000_00C2);
    chk("R9 pin15", dv(15), 6);
    chk("R9 split kept", dv(13), 5);
    wr(8'h38, 32'h8000_0000);
    rd(8'h38, v); chk("R9 first reg", v, 0);
    chk("R9 split low cleared", dv(13), 4);
  endtask

  task automatic t_pull();
    logic [31:0] v;
    logic [31:0] encb [4] = '{0, 2, 0, 1};
    wr(8'h20, 32'hFFFF_E4E4);
    wr(8'h24, 32'hFFFF_E4E4);
    rd(8'h24, v); chk("R10 readback", v, 32'h0000_E4E4);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R10 encA pin%0d", k), pl(k), 32'(k % 4));
      chk($sformatf("R10 encB pin%0d", 8 + k), pl(8 + k), encb[k % 4]);
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R11 read 0x50", v, 0);
    rd(8'h02, v); chk("R11 read 0x02", v, 0);
    rd(8'h1C, v); chk("R11 read 0x1C", v, 0);
    rd(8'h00, v); chk("R11 reg 0x00 kept", v, 32'h0000_A0F5);
    rd(8'h04, v); chk("R11 reg 0x04 kept", v, 32'h0000_58D1);
    chk("R11 pin0 kept", fn(0), 1);
    chk("R11 pin13 drive kept", dv(13), 4);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_0003);
    chk("R12 pin0 one edge later still old", fn(0), 1);
    @(negedge clk);
    chk("R12 pin0 updated", fn(0), 3);
    chk("R12 pin6 updated", fn(6), 0);
    @(negedge clk); addr = 8'h24;
    @(negedge clk); v = rdata;
    chk("R12 read latency", v, 32'h0000_E4E4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask_2bit();
    t_mux3();
    t_mux4_plain();
    t_gpio_only();
    t_drive();
    t_pull();
    t_unmapped();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule